// File: doc/BRIEF.md
# Calendar Shadow Snapshot Unit

This unit gives a fast bus domain a consistent view of three calendar counters: a sub-second count, a time word and a date word. The counters run in a slow clock domain. Every two slow-clock cycles the slow side captures all three into a holding register and flips a request bit. The bus side synchronises that bit, and on each flip it loads the holding register into three shadow registers in a single cycle. A sync-done flag then rises to show that fresh data has arrived. Software clears the flag and waits for it to rise again before it reads.

A read of the sub-second or time shadow starts a lock. While the lock is held, no copy is applied, so the three words that software reads in one sequence all come from the same snapshot. A read of the date shadow ends the lock. When the bypass control is set, reads return the live counters directly, and these reads never lock.

Top module: `cal_shadow_snap`

## Requirements
- R1: The slow domain captures the live counters and issues one copy request every two slow-clock cycles. With no lock active, consecutive copies land exactly 16 bus cycles apart when the slow clock is 8 times slower than the bus clock.
- R2: Each applied copy loads all three shadow registers from one capture, and sets sync_done on the clock edge where the copy lands.
- R3: Asserting sync_clr for one cycle clears sync_done at the next edge. Only a later applied copy sets it again, and a copy that lands in the same cycle as a clear leaves the flag set.
- R4: In shadow mode (byp_en = 0), a read with rd_sel = 0 (sub-second) or rd_sel = 1 (time) starts a lock. Copies that arrive while the lock is held are dropped, the shadows keep their values, and sync_done is not set.
- R5: A shadow-mode read with rd_sel = 2 (date) releases the lock in the same cycle. A copy that arrives in that cycle is applied, and copies resume afterwards.
- R6: Synchronous reset clears every shadow register to zero, clears sync_done and clears the lock.
- R7: With byp_en = 1, rd_data returns the live counter for the selected field, whatever the state of sync_done. Reads in this mode never start a lock.
- R8: rd_data is combinational on rd_sel. The codes are 0 for sub-second (16 bits), 1 for time (24 bits) and 2 for date (24 bits), each zero-extended to 32 bits. Code 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| cal_clk | input | 1 | Slow calendar clock |
| cal_rst | input | 1 | Synchronous active-high reset, calendar domain |
| live_subsec | input | 16 | Live sub-second counter (calendar domain) |
| live_time | input | 24 | Live time counter (calendar domain) |
| live_date | input | 24 | Live date counter (calendar domain) |
| byp_en | input | 1 | 1: reads return the live counters; 0: reads return the shadows |
| rd_en | input | 1 | Read strobe, one bus cycle per access |
| rd_sel | input | 2 | Field select: 0 sub-second, 1 time, 2 date, 3 none |
| sync_clr | input | 1 | Software clear of the sync-done flag |
| rd_data | output | 32 | Selected field, zero-extended |
| sync_done | output | 1 | Set when a copy lands in the shadows |

## Verification
The single-pulse check on the copy event assumes that the bus clock is several times faster than the slow clock, so the request bit never flips twice within two bus cycles. The stimulus keeps the ratio at eight. The bench changes the live counters only on slow-clock falling edges, and then waits several slow cycles before it expects them in the holding register. The slow-clock edges are offset from the bus edges, so synchroniser latency is fixed and copy intervals can be checked to the exact cycle. Read strobes are one cycle wide and are separated by idle cycles, as a bus would issue them.

// File: rtl/cal_shadow_pkg.sv
package cal_shadow_pkg;

    localparam int SS_W  = 16;
    localparam int TM_W  = 24;
    localparam int DT_W  = 24;
    localparam int BUS_W = 32;

    typedef struct packed {
        logic [DT_W-1:0] dt;
        logic [TM_W-1:0] tm;
        logic [SS_W-1:0] ss;
    } cal_snap_t;

    typedef enum logic [1:0] {
        SEL_SUBSEC = 2'd0,
        SEL_TIME   = 2'd1,
        SEL_DATE   = 2'd2,
        SEL_NONE   = 2'd3
    } cal_sel_e;

    function automatic logic [BUS_W-1:0] pick_field(cal_snap_t s, cal_sel_e sel);
        logic [BUS_W-1:0] r;
        case (sel)
            SEL_SUBSEC: r = {{(BUS_W-SS_W){1'b0}}, s.ss};
            SEL_TIME:   r = {{(BUS_W-TM_W){1'b0}}, s.tm};
            SEL_DATE:   r = {{(BUS_W-DT_W){1'b0}}, s.dt};
            default:    r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cs_copy_pulse.sv
module cs_copy_pulse
    import cal_shadow_pkg::*;
#(
    parameter int DIV = 2
) (
    input  logic      cal_clk,
    input  logic      cal_rst,
    input  cal_snap_t live,
    output logic      req_tog,
    output cal_snap_t hold
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          req_q;
    cal_snap_t     hold_q;

    always_ff @(posedge cal_clk) begin
        if (cal_rst) begin
            cnt_q  <= '0;
            req_q  <= 1'b0;
            hold_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            req_q  <= ~req_q;
            hold_q <= live;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign req_tog = req_q;
    assign hold    = hold_q;

    // R1: a request flips only when the divider has just completed its period
    a_r1_copy_period: assert property (@(posedge cal_clk) disable iff (cal_rst)
        (req_q != $past(req_q)) |-> ($past(cnt_q) == LAST));

    // R1: the holding register only changes together with a request flip
    a_r1_hold_with_req: assert property (@(posedge cal_clk) disable iff (cal_rst)
        (hold_q != $past(hold_q)) |-> (req_q != $past(req_q)));

endmodule

// File: rtl/cs_toggle_sync.sv
module cs_toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic bus_clk,
    input  logic bus_rst,
    input  logic tog_in,
    output logic evt_out
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge bus_clk) begin
        if (bus_rst) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-1:0], tog_in};
    end

    assign evt_out = chain_q[STAGES] ^ chain_q[STAGES-1];

    // R1: with the bus clock well above the slow clock, each event is a single cycle
    a_r1_single_pulse: assert property (@(posedge bus_clk) disable iff (bus_rst)
        evt_out |=> !evt_out);

endmodule

// File: rtl/cs_shadow_bank.sv
module cs_shadow_bank
    import cal_shadow_pkg::*;
(
    input  logic             bus_clk,
    input  logic             bus_rst,
    input  logic             copy_evt,
    input  cal_snap_t        hold,
    input  cal_snap_t        live,
    input  logic             byp_en,
    input  logic             rd_en,
    input  cal_sel_e         rd_sel,
    input  logic             sync_clr,
    output logic [BUS_W-1:0] rd_data,
    output logic             sync_done
);
    cal_snap_t shadow_q;
    logic      lock_q;
    logic      sync_q;
    logic      rst_seen_q;

    logic rd_lower, rd_date, lock_eff, copy_apply;

    always_comb begin
        rd_lower   = rd_en && !byp_en && (rd_sel == SEL_SUBSEC || rd_sel == SEL_TIME);
        rd_date    = rd_en && !byp_en && (rd_sel == SEL_DATE);
        lock_eff   = (lock_q || rd_lower) && !rd_date;
        copy_apply = copy_evt && !lock_eff;
    end

    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            shadow_q <= '0;
            lock_q   <= 1'b0;
            sync_q   <= 1'b0;
        end else begin
            lock_q <= lock_eff;
            if (copy_apply) shadow_q <= hold;
            if (copy_apply)    sync_q <= 1'b1;
            else if (sync_clr) sync_q <= 1'b0;
        end
    end

    always_ff @(posedge bus_clk) rst_seen_q <= bus_rst;

    assign rd_data   = pick_field(byp_en ? live : shadow_q, rd_sel);
    assign sync_done = sync_q;

    // R6: the first cycle after reset shows cleared state
    a_r6_reset_state: assert property (@(posedge bus_clk) disable iff (bus_rst)
        rst_seen_q |-> (!sync_q && !lock_q && shadow_q == '0));

    // R2: the flag rises only after a copy event
    a_r2_flag_on_copy: assert property (@(posedge bus_clk) disable iff (bus_rst)
        $rose(sync_q) |-> $past(copy_evt));

    // R3: a clear with no copy drops the flag
    a_r3_clear: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (sync_clr && !copy_evt) |=> !sync_q);

    // R3: a copy in the same cycle as a clear leaves the flag set
    a_r3_set_wins: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (copy_evt && !lock_q && !rd_en) |=> sync_q);

    // R4: a held lock with no date read freezes the shadows
    a_r4_locked_hold: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (lock_q && !(rd_en && !byp_en && rd_sel == SEL_DATE)) |=> $stable(shadow_q));

    // R5: a shadow-mode date read leaves no lock behind
    a_r5_date_release: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (rd_en && !byp_en && rd_sel == SEL_DATE) |=> !lock_q);

    // R7: bypass reads never start a lock
    a_r7_bypass_no_lock: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (byp_en && !lock_q) |=> !lock_q);

endmodule

// File: rtl/cal_shadow_snap.sv
module cal_shadow_snap
    import cal_shadow_pkg::*;
#(
    parameter int COPY_DIV    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             bus_clk,
    input  logic             bus_rst,
    input  logic             cal_clk,
    input  logic             cal_rst,
    input  logic [SS_W-1:0]  live_subsec,
    input  logic [TM_W-1:0]  live_time,
    input  logic [DT_W-1:0]  live_date,
    input  logic             byp_en,
    input  logic             rd_en,
    input  logic [1:0]       rd_sel,
    input  logic             sync_clr,
    output logic [BUS_W-1:0] rd_data,
    output logic             sync_done
);
    cal_snap_t live_s;
    cal_snap_t hold_s;
    logic      req_tog;
    logic      copy_evt;

    assign live_s = '{dt: live_date, tm: live_time, ss: live_subsec};

    cs_copy_pulse #(.DIV(COPY_DIV)) u_pulse (
        .cal_clk (cal_clk),
        .cal_rst (cal_rst),
        .live    (live_s),
        .req_tog (req_tog),
        .hold    (hold_s)
    );

    cs_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .bus_clk (bus_clk),
        .bus_rst (bus_rst),
        .tog_in  (req_tog),
        .evt_out (copy_evt)
    );

    cs_shadow_bank u_bank (
        .bus_clk   (bus_clk),
        .bus_rst   (bus_rst),
        .copy_evt  (copy_evt),
        .hold      (hold_s),
        .live      (live_s),
        .byp_en    (byp_en),
        .rd_en     (rd_en),
        .rd_sel    (cal_sel_e'(rd_sel)),
        .sync_clr  (sync_clr),
        .rd_data   (rd_data),
        .sync_done (sync_done)
    );

endmodule

// File: tb/cal_shadow_snap_tb_top.sv
`timescale 1ns/1ps
module cal_shadow_snap_tb_top;

    logic        bus_clk = 1'b0;
    logic        cal_clk = 1'b0;
    logic        bus_rst = 1'b1;
    logic        cal_rst = 1'b1;
    logic [15:0] live_subsec = '0;
    logic [23:0] live_time = '0;
    logic [23:0] live_date = '0;
    logic        byp_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_sel = 2'd0;
    logic        sync_clr = 1'b0;
    logic [31:0] rd_data;
    logic        sync_done;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 bus_clk = ~bus_clk;
    initial begin
        #1;
        forever #16 cal_clk = ~cal_clk;
    end

    cal_shadow_snap dut_i (
        .bus_clk(bus_clk), .bus_rst(bus_rst), .cal_clk(cal_clk), .cal_rst(cal_rst),
        .live_subsec(live_subsec), .live_time(live_time), .live_date(live_date),
        .byp_en(byp_en), .rd_en(rd_en), .rd_sel(rd_sel), .sync_clr(sync_clr),
        .rd_data(rd_data), .sync_done(sync_done)
    );

    always @(posedge bus_clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: samples away from the clock edge
    always @(negedge bus_clk) begin
        if (rd_en) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard empty", rd_data, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data === e, t, rd_data, e);
            end
        end
    end

    task automatic do_read(input logic [1:0] sel, input logic [31:0] exp, input string tag);
        @(posedge bus_clk); #1;
        rd_en = 1'b1; rd_sel = sel;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(posedge bus_clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic set_live(input logic [15:0] s, input logic [23:0] t, input logic [23:0] d);
        @(negedge cal_clk);
        live_subsec = s; live_time = t; live_date = d;
    endtask

    task automatic wait_cal(input int n);
        for (int i = 0; i < n; i++) @(negedge cal_clk);
    endtask

    task automatic clear_sync();
        @(posedge bus_clk); #1;
        sync_clr = 1'b1;
        @(posedge bus_clk); #1;
        sync_clr = 1'b0;
    endtask

    task automatic wait_set(input int max, input string tag, output int stamp);
        int n;
        n = 0;
        @(negedge bus_clk);
        while (!sync_done && n < max) begin
            @(negedge bus_clk);
            n++;
        end
        check(sync_done === 1'b1, tag, {31'b0, sync_done}, 32'h1);
        stamp = cyc;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (60000) @(posedge bus_clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            finish_run();
        end
    end

    initial begin
        int t0, t1, tmp;
        repeat (6) @(posedge bus_clk);
        #1;
        bus_rst = 1'b0; cal_rst = 1'b0;

        // R6: reset state
        @(negedge bus_clk);
        check(sync_done === 1'b0, "R6 sync_done after reset", {31'b0, sync_done}, 32'h0);
        do_read(2'd0, 32'h0, "R6 subsec shadow reset");
        do_read(2'd1, 32'h0, "R6 time shadow reset");
        do_read(2'd2, 32'h0, "R6 date shadow reset");

        // R2, R8: fresh copy observed
        set_live(16'hA5C3, 24'h123456, 24'h250614);
        wait_cal(5);
        clear_sync();
        wait_set(60, "R2 flag after copy", tmp);
        do_read(2'd0, 32'h0000A5C3, "R2 subsec copy");
        do_read(2'd1, 32'h00123456, "R2 time copy");
        do_read(2'd2, 32'h00250614, "R8 date copy zero-extended");
        do_read(2'd3, 32'h0, "R8 code 3 reads zero");

        // R1, R3: copy spacing and clear behaviour
        clear_sync();
        wait_set(60, "R1 first aligned copy", t0);
        for (int k = 0; k < 3; k++) begin
            clear_sync();
            @(negedge bus_clk);
            check(sync_done === 1'b0, "R3 clear drops flag", {31'b0, sync_done}, 32'h0);
            wait_set(60, "R3 flag set again by copy", t1);
            check((t1 - t0) == 16, "R1 copy interval", t1 - t0, 32'd16);
            t0 = t1;
        end

        // R4: lock after subsec read
        set_live(16'h1111, 24'h222222, 24'h333333);
        wait_cal(5);
        clear_sync();
        wait_set(60, "R2 flag before lock", tmp);
        do_read(2'd0, 32'h00001111, "R4 subsec read starts lock");
        set_live(16'h4444, 24'h555555, 24'h666666);
        wait_cal(5);
        clear_sync();
        @(negedge bus_clk);
        check(sync_done === 1'b0, "R3 clear while locked", {31'b0, sync_done}, 32'h0);
        repeat (48) @(negedge bus_clk);
        check(sync_done === 1'b0, "R4 skipped copies leave flag low", {31'b0, sync_done}, 32'h0);
        do_read(2'd1, 32'h00222222, "R4 time held by lock");
        do_read(2'd2, 32'h00333333, "R4 date held by lock");

        // R5: date read released the lock
        wait_set(60, "R5 copies resume after date read", tmp);
        do_read(2'd0, 32'h00004444, "R5 subsec after release");
        do_read(2'd1, 32'h00555555, "R5 time after release");
        do_read(2'd2, 32'h00666666, "R5 date after release");

        // R7: bypass
        byp_en = 1'b1;
        clear_sync();
        set_live(16'h7777, 24'h888888, 24'h999999);
        @(negedge bus_clk);
        do_read(2'd0, 32'h00007777, "R7 bypass subsec live");
        do_read(2'd1, 32'h00888888, "R7 bypass time live");
        do_read(2'd2, 32'h00999999, "R7 bypass date live");
        do_read(2'd3, 32'h0, "R8 code 3 in bypass");
        do_read(2'd0, 32'h00007777, "R7 bypass read no lock");
        wait_cal(5);
        clear_sync();
        wait_set(60, "R7 copies continue after bypass reads", tmp);
        byp_en = 1'b0;
        do_read(2'd2, 32'h00999999, "R7 shadow updated during bypass");

        repeat (4) @(posedge bus_clk);
        done = 1'b1;
        finish_run();
    end

endmodule